// File: doc/BRIEF.md
# PCI Target Read Prefetcher

This block sits behind the read side of a PCI target. When a Memory Read or Memory Read Multiple transaction begins, it requests data from an on-chip read port in blocks and holds the returned 32-bit words in a small FIFO until the bus side consumes them. It does not wait for the FIFO to run empty. A new block is requested as soon as the count of fetched but unconsumed words falls to a programmable threshold, so the bus side sees a steady supply of data.

The block size depends on the command. For Memory Read it is a word count. For Memory Read Multiple it is a power-of-two byte size, which is converted to whole words. Only one block request is outstanding at a time. Each new request starts at the byte just after the end of the previous block. When the transaction terminates, the unread data is discarded and the occupancy goes to zero. Words still owed by an acknowledged request are swallowed before the block goes idle.

The controller has five named states:
- IDLE waits for `txn_start`.
- ISSUE drives the request and leaves for FILL on `req_ack`.
- FILL counts returned words. It leaves for WATCH on the last word, or for DRAIN on `txn_end`.
- WATCH waits until occupancy is at or below the effective threshold, then goes back to ISSUE.
- DRAIN discards the words still owed, then returns to IDLE.

A `txn_end` in ISSUE or WATCH returns to IDLE directly.

Top module: `pci_rd_prefetch`

## Requirements
- R1: After reset the block is idle. `req_valid` is 0, `occupancy` is 0 and `data_valid` is 0.
- R2: For Memory Read (`cmd_mrm` = 0) the requested block is `cfg_mr_words` + 1 words. Field value 7 gives 8 words, and field value 31 gives the largest block of 32 words.
- R3: For Memory Read Multiple (`cmd_mrm` = 1) the block is 8 << `cfg_mrm_code` bytes, requested as 2 << code words. Code 0 gives 2 words and code 7 gives 256 words.
- R4: `txn_start` in IDLE latches `start_addr`. `req_valid` rises one cycle later with `req_addr` equal to `start_addr`.
- R5: Each refill request address equals the previous request address plus 4 × the previous block size in words.
- R6: At most one request is outstanding. `req_valid` stays low from the acknowledge until every word of that block has been returned.
- R7: While the block is waiting to refill, a new request is issued in the cycle after the cycle in which `occupancy` is at or below the effective threshold. No request is issued while occupancy is above it.
- R8: The effective threshold is `cfg_threshold` (in words) when that value is below the block size. Otherwise it is the block size minus one.
- R9: Returned words are delivered on `data_out` in arrival order. `occupancy` counts words written but not yet consumed, and `data_valid` is high whenever `occupancy` is nonzero.
- R10: `txn_end` empties the FIFO. In the next cycle `occupancy` is 0 and `req_valid` is 0, and words of an acknowledged block that arrive afterwards are discarded.
- R11: Once raised, `req_valid`, `req_addr` and `req_words` hold steady until `req_ack` or `txn_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txn_start | input | 1 | Start of a read transaction (pulse) |
| cmd_mrm | input | 1 | 1 = Memory Read Multiple, 0 = Memory Read |
| start_addr | input | 32 | Byte address of the transaction |
| txn_end | input | 1 | Transaction terminated (pulse) |
| consume | input | 1 | Bus side takes one word |
| cfg_mr_words | input | 5 | Memory Read block size minus one, in words |
| cfg_mrm_code | input | 3 | Memory Read Multiple size code |
| cfg_threshold | input | 4 | Refill threshold in words |
| req_valid | output | 1 | Block request pending |
| req_addr | output | 32 | Byte address of the request |
| req_words | output | 9 | Size of the request in words |
| req_ack | input | 1 | Request accepted |
| rsp_valid | input | 1 | One returned word is present |
| rsp_data | input | 32 | Returned word |
| data_out | output | 32 | Oldest unconsumed word |
| data_valid | output | 1 | `data_out` holds a word |
| occupancy | output | 10 | Unconsumed words held |

## Verification
The bench sweeps both commands at the smallest and largest block sizes, including a one-word Memory Read and a 256-word Memory Read Multiple.
- **Block size.** A sizing error that used bytes instead of words would request four times too much.
- **Threshold boundary.** The bench steps occupancy down through threshold + 1 and then the threshold itself. A design that compared with `<` would stall one word late, and one that waited for an empty FIFO would show no request at all.
- **Clamping.** Thresholds equal to or above the block size exercise the clamp. Without it, refills would fire immediately after every fill.
- **Termination.** A transaction is ended in mid-fill and late words are then delivered. A design without draining would leave stale words in the next transaction's FIFO.

// File: rtl/pci_rd_prefetch_pkg.sv
package pci_rd_prefetch_pkg;

    localparam int SIZE_W = 9;

    typedef enum logic [2:0] {
        IDLE,
        ISSUE,
        FILL,
        WATCH,
        DRAIN
    } pf_state_t;

endpackage

// File: rtl/pf_size_sel.sv
module pf_size_sel
    import pci_rd_prefetch_pkg::*;
(
    input  logic              cmd_mrm,
    input  logic [4:0]        mr_words,
    input  logic [2:0]        mrm_code,
    input  logic [3:0]        thr_raw,
    output logic [SIZE_W-1:0] blk_words,
    output logic [SIZE_W-1:0] thr_eff
);
    logic [SIZE_W-1:0] thr_ext;

    always_comb begin
        if (cmd_mrm)
            blk_words = SIZE_W'(2) << mrm_code;
        else
            blk_words = SIZE_W'(mr_words) + SIZE_W'(1);
        thr_ext = SIZE_W'(thr_raw);
        thr_eff = (thr_ext >= blk_words) ? blk_words - SIZE_W'(1) : thr_ext;
    end
endmodule

// File: rtl/pf_word_fifo.sv
module pf_word_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_wr;
    logic              do_rd;

    assign do_rd   = rd_en && (count != '0);
    assign do_wr   = wr_en && (count != CNT_W'(DEPTH));
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_rd) rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end
endmodule

// File: rtl/pci_rd_prefetch.sv
module pci_rd_prefetch
    import pci_rd_prefetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              cmd_mrm,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              txn_end,
    input  logic              consume,
    input  logic [4:0]        cfg_mr_words,
    input  logic [2:0]        cfg_mrm_code,
    input  logic [3:0]        cfg_threshold,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SIZE_W-1:0] req_words,
    input  logic              req_ack,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic [CNT_W-1:0]  occupancy
);
    pf_state_t         state, nxt;
    logic              cmd_q;
    logic              cmd_sel;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] words_q;
    logic [SIZE_W-1:0] rem_q;
    logic [SIZE_W-1:0] size_words;
    logic [SIZE_W-1:0] thr_eff;
    logic              last_word;
    logic              below_thr;
    logic              fifo_wr;
    logic              flush;

    assign cmd_sel = (state == IDLE) ? cmd_mrm : cmd_q;

    pf_size_sel u_size (
        .cmd_mrm   (cmd_sel),
        .mr_words  (cfg_mr_words),
        .mrm_code  (cfg_mrm_code),
        .thr_raw   (cfg_threshold),
        .blk_words (size_words),
        .thr_eff   (thr_eff)
    );

    assign last_word = rsp_valid && (rem_q == SIZE_W'(1));
    assign below_thr = occupancy <= CNT_W'(thr_eff);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            IDLE:  if (txn_start && !txn_end) nxt = ISSUE;
            ISSUE: if (txn_end) nxt = IDLE;
                   else if (req_ack) nxt = FILL;
            FILL:  if (last_word) nxt = txn_end ? IDLE : WATCH;
                   else if (txn_end) nxt = DRAIN;
            WATCH: if (txn_end) nxt = IDLE;
                   else if (below_thr) nxt = ISSUE;
            DRAIN: if (last_word) nxt = IDLE;
            default: nxt = IDLE;
        endcase
    end

    // Request bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= 1'b0;
            addr_q  <= '0;
            words_q <= '0;
            rem_q   <= '0;
        end else begin
            if (state == IDLE && txn_start) begin
                cmd_q   <= cmd_mrm;
                addr_q  <= start_addr;
                words_q <= size_words;
            end
            if (state == WATCH && nxt == ISSUE)
                words_q <= size_words;
            if (state == ISSUE && req_ack && !txn_end) begin
                rem_q  <= words_q;
                addr_q <= addr_q + (ADDR_W'(words_q) << 2);
            end
            if ((state == FILL || state == DRAIN) && rsp_valid)
                rem_q <= rem_q - SIZE_W'(1);
        end
    end

    // Outputs
    always_comb begin
        req_valid = (state == ISSUE);
        req_addr  = addr_q;
        req_words = words_q;
        fifo_wr   = (state == FILL) && rsp_valid && !txn_end;
        flush     = txn_end;
    end

    pf_word_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (fifo_wr),
        .wr_data (rsp_data),
        .rd_en   (consume),
        .rd_data (data_out),
        .count   (occupancy)
    );

    assign data_valid = (occupancy != '0);
endmodule

// File: rtl/pci_rd_prefetch_chk.sv
module pci_rd_prefetch_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 512,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_start,
    input logic              txn_end,
    input logic              req_valid,
    input logic              req_ack,
    input logic [ADDR_W-1:0] req_addr,
    input logic [8:0]        req_words,
    input logic              cmd_q,
    input logic [8:0]        thr_eff,
    input logic [CNT_W-1:0]  occupancy
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack && !txn_end |=> req_valid && $stable(req_addr) && $stable(req_words));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |=> (occupancy == '0) && !req_valid);

    // R7
    refill_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) && !$past(txn_start) |-> $past(occupancy) <= CNT_W'($past(thr_eff)));

    // R3
    mrm_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cmd_q |-> $countones(req_words) == 1);
endmodule

bind pci_rd_prefetch pci_rd_prefetch_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_start (txn_start),
    .txn_end   (txn_end),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_addr  (req_addr),
    .req_words (req_words),
    .cmd_q     (cmd_q),
    .thr_eff   (thr_eff),
    .occupancy (occupancy)
);

// File: tb/pci_rd_prefetch_test.sv
module pci_rd_prefetch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0;
    logic        cmd_mrm = 1'b0;
    logic [31:0] start_addr = '0;
    logic        txn_end = 1'b0;
    logic        consume = 1'b0;
    logic [4:0]  cfg_mr_words = 5'd7;
    logic [2:0]  cfg_mrm_code = 3'd1;
    logic [3:0]  cfg_threshold = 4'd3;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [8:0]  req_words;
    logic        req_ack = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic [31:0] data_out;
    logic        data_valid;
    logic [9:0]  occupancy;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pci_rd_prefetch uut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // {cmd, mr_field, code, thr, words, eff_thr}
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 5'd7,  3'd0, 4'd3,  9'd8,   4'd3},
        {1'b0, 5'd0,  3'd0, 4'd5,  9'd1,   4'd0},
        {1'b0, 5'd31, 3'd0, 4'd15, 9'd32,  4'd15},
        {1'b1, 5'd0,  3'd1, 4'd3,  9'd4,   4'd3},
        {1'b1, 5'd0,  3'd0, 4'd3,  9'd2,   4'd1},
        {1'b1, 5'd0,  3'd7, 4'd10, 9'd256, 4'd10},
        {1'b1, 5'd0,  3'd3, 4'd15, 9'd16,  4'd15},
        {1'b0, 5'd3,  3'd0, 4'd4,  9'd4,   4'd3}
    };

    task automatic feed(input int n, input logic [31:0] base);
        for (int k = 0; k < n; k++) begin
            rsp_valid = 1'b1;
            rsp_data  = base + 32'(k);
            @(negedge clk);
            check(!req_valid, "R6 no second request during fill", 32'(req_valid), 0);
        end
        rsp_valid = 1'b0;
    endtask

    task automatic run_vec(input int i);
        logic [25:0] v;
        logic [31:0] base, a0;
        int words, eff, idx;
        v     = VEC[i];
        words = int'(v[12:4]);
        eff   = int'(v[3:0]);
        a0    = 32'h1000_0000 + 32'(i) * 32'h0001_0000;
        base  = 32'hA000_0000 + 32'(i) * 32'h1000;
        cmd_mrm = v[25]; cfg_mr_words = v[24:20]; cfg_mrm_code = v[19:17]; cfg_threshold = v[16:13];
        start_addr = a0;
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
        check(req_valid && req_addr == a0, "R4 first request address", req_addr, a0);
        check(req_words == 9'(words), v[25] ? "R3 MRM block words" : "R2 MR block words", 32'(req_words), 32'(words));
        @(negedge clk);
        check(req_valid && req_addr == a0 && req_words == 9'(words), "R11 request held without ack", 32'(req_valid), 1);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        check(!req_valid, "R6 request drops after ack", 32'(req_valid), 0);
        feed(words, base);
        check(occupancy == 10'(words), "R9 occupancy after fill", 32'(occupancy), 32'(words));
        idx = 0;
        while (1) begin
            if (int'(occupancy) <= eff + 1) begin
                consume = 1'b0;
                break;
            end
            if (data_out != base + 32'(idx))
                check(0, "R9 data order", data_out, base + 32'(idx));
            consume = 1'b1;
            idx++;
            @(negedge clk);
        end
        @(negedge clk);
        check(!req_valid && occupancy == 10'(eff + 1), "R7 no refill above threshold", 32'(occupancy), 32'(eff + 1));
        check(data_valid && data_out == base + 32'(idx), "R9 next word in order", data_out, base + 32'(idx));
        consume = 1'b1;
        @(negedge clk);
        consume = 1'b0;
        check(occupancy == 10'(eff), "R8 occupancy at effective threshold", 32'(occupancy), 32'(eff));
        @(negedge clk);
        check(req_valid, "R7 refill at threshold", 32'(req_valid), 1);
        check(req_addr == a0 + 32'(words * 4), "R5 contiguous refill address", req_addr, a0 + 32'(words * 4));
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
        check(!req_valid && occupancy == 0 && !data_valid, "R10 flush on end", 32'(occupancy), 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!req_valid && occupancy == 0 && !data_valid, "R1 reset state", 32'(occupancy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && occupancy == 0, "R1 idle after reset", 32'(req_valid), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // End of transaction in the middle of a fill: remaining words are swallowed
        cmd_mrm = 1'b0; cfg_mr_words = 5'd3; cfg_threshold = 4'd0;
        start_addr = 32'h2000_0000;
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        feed(2, 32'h5500);
        check(occupancy == 2, "R9 partial fill count", 32'(occupancy), 2);
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
        check(occupancy == 0, "R10 flush mid fill", 32'(occupancy), 0);
        feed(2, 32'h6600);
        check(occupancy == 0 && !data_valid, "R10 late words discarded", 32'(occupancy), 0);
        start_addr = 32'h3000_0040;
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
        check(req_valid && req_addr == 32'h3000_0040, "R4 fresh request after drain", req_addr, 32'h3000_0040);
        check(req_words == 9'd4, "R2 MR block after drain", 32'(req_words), 4);
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
        check(!req_valid, "R10 end drops unacknowledged request", 32'(req_valid), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule